// File: doc/BRIEF.md
# Masked Register Power-Sequence Engine

This block walks a fixed table of power-sequence steps and carries out each one on a simple 8-bit register bus. The table is a parameter, so it is built into the hardware. Each step names a register by a 4-bit space selector and a 16-bit offset. It then does one of five things: a masked read, a masked read-modify-write, a poll with a bounded number of attempts, a timed wait in microseconds or milliseconds, or the end of the sequence.

Three configuration inputs describe the chip the sequence runs on: its silicon revision, its fabrication site and its host link. Each is one-hot. A step runs only if each of its three selection masks shares a set bit with the matching input. Any other step is passed over without a bus cycle.

A one-cycle `start` launches the sequence. `busy` stays high while the table is being walked. `done` rises at the end and stays high until the next start. `error` rises together with `done` when a poll runs out of attempts, when an undefined command code is met, or when the table runs out before an end step. In each of those cases `fail_idx` gives the index of the step at fault.

Top module: `pwrseq_engine`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `bus_rd` and `bus_wr` are all 0.
- R2: A step whose revision, site or link mask has no set bit in common with `cfg_cut`, `cfg_fab` or `cfg_port` makes no bus access. A mask of all ones matches any setting.
- R3: A read step (command code 0) completes one read and captures (read data AND mask) on `rd_value`.
- R4: A write step (command code 1) reads the register and then writes back (old AND NOT mask) OR (value AND mask). Both accesses use address {space[3:0], offset[15:0]}.
- R5: A poll step (command code 2) repeats reads until (data AND mask) equals (value AND mask), then moves on. A match on the final allowed attempt counts as success.
- R6: If a poll makes POLL_LIMIT attempts with no match, the engine stops and raises `done` and `error`. `fail_idx` is set to that step's index. No further bus access follows.
- R7: A wait step (command code 3) holds for offset × unit, with no bus access. Bit 0 of the value field selects the unit: 0 is CYC_PER_US clocks, 1 is CYC_PER_US × US_PER_MS clocks.
- R8: An end step (command code 4) raises `done` with `error` low and drops `busy`. `done` and `error` then hold until the next `start`.
- R9: Walking past the last table entry without an end step raises `done` and `error`, with `fail_idx` equal to N_ENTRIES.
- R10: `bus_rd` and `bus_wr` are never high together. The address and write data hold steady until `bus_ready` completes the access.
- R11: A `start` pulse while `busy` is high is ignored.
- R12: A command code above 4 raises `done` and `error`, with `fail_idx` set to that step's index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle launch of the sequence |
| cfg_cut | input | 8 | One-hot silicon revision |
| cfg_fab | input | 4 | One-hot fabrication site |
| cfg_port | input | 4 | One-hot host link |
| bus_rd | output | 1 | Read request, held until ready |
| bus_wr | output | 1 | Write request, held until ready |
| bus_addr | output | 20 | {space, offset} of the access |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid when ready |
| bus_ready | input | 1 | Completes the current access |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished (held) |
| error | output | 1 | Sequence finished with a fault |
| fail_idx | output | $clog2(N_ENTRIES+1) | Index of the faulting step |
| rd_value | output | 8 | Masked result of the last read step |

## Verification
On the poll step, the match condition and the end of the attempt budget can fall in the same cycle: the last permitted read may also be the one that returns the awaited value. The bench's register model makes the polled register match only after a chosen number of completed reads. Directed runs set that number to exactly POLL_LIMIT−1, which must succeed, and to POLL_LIMIT, which must time out at the poll step's index. Random runs spread the number around that boundary. The outcome is judged from the error flag, the fail index and the model's count of completed poll reads.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    localparam int ENTRY_W = 56;

    typedef enum logic [3:0] {
        OP_READ  = 4'd0,
        OP_WRITE = 4'd1,
        OP_POLL  = 4'd2,
        OP_DELAY = 4'd3,
        OP_END   = 4'd4
    } op_e;

    // Field order is the packing of one table entry, most significant first.
    typedef struct packed {
        logic [15:0] offset;
        logic [7:0]  cut_sel;
        logic [3:0]  fab_sel;
        logic [3:0]  port_sel;
        logic [3:0]  space;
        logic [3:0]  op;
        logic [7:0]  bitmask;
        logic [7:0]  data;
    } step_t;

    localparam step_t STOP_STEP = '{
        offset: 16'h0000, cut_sel: 8'hFF, fab_sel: 4'hF, port_sel: 4'hF,
        space: 4'h0, op: 4'd4, bitmask: 8'h00, data: 8'h00
    };

    typedef enum logic [2:0] {
        ST_IDLE, ST_EVAL, ST_READ, ST_WRITE, ST_WAIT, ST_DONE
    } state_e;

endpackage

// File: rtl/pwrseq_match.sv
module pwrseq_match (
    input  logic [7:0] cut_sel,
    input  logic [3:0] fab_sel,
    input  logic [3:0] port_sel,
    input  logic [7:0] cfg_cut,
    input  logic [3:0] cfg_fab,
    input  logic [3:0] cfg_port,
    output logic       hit
);
    always_comb begin
        hit = (|(cut_sel & cfg_cut)) && (|(fab_sel & cfg_fab)) && (|(port_sel & cfg_port));
    end
endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
    parameter int CYC_PER_US = 125,
    parameter int US_PER_MS  = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [15:0] amount,
    input  logic        unit_ms,
    output logic        expired
);
    localparam int PRE_W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
    localparam int MS_W  = (US_PER_MS > 1) ? $clog2(US_PER_MS) : 1;

    typedef struct packed {
        logic [15:0]      rem;
        logic [PRE_W-1:0] pre;
        logic [MS_W-1:0]  msc;
        logic             ms;
    } tm_t;

    tm_t  tm_d, tm_q;
    logic us_tick, unit_tick;

    always_comb begin
        tm_d      = tm_q;
        us_tick   = (tm_q.pre == PRE_W'(CYC_PER_US - 1));
        unit_tick = tm_q.ms ? (us_tick && (tm_q.msc == MS_W'(US_PER_MS - 1))) : us_tick;
        tm_d.pre  = us_tick ? '0 : tm_q.pre + 1'b1;
        if (us_tick && tm_q.ms) begin
            tm_d.msc = (tm_q.msc == MS_W'(US_PER_MS - 1)) ? '0 : tm_q.msc + 1'b1;
        end
        if (unit_tick && (tm_q.rem != '0)) begin
            tm_d.rem = tm_q.rem - 16'd1;
        end
        if (load) begin
            tm_d.rem = amount;
            tm_d.pre = '0;
            tm_d.msc = '0;
            tm_d.ms  = unit_ms;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tm_q <= '0;
        else        tm_q <= tm_d;
    end

    assign expired = (tm_q.rem == '0);

    AST_REM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (tm_q.rem == $past(tm_q.rem)) || (tm_q.rem == $past(tm_q.rem) - 16'd1))
        else $error("remaining count jumped"); // R7

endmodule

// File: rtl/pwrseq_engine.sv
module pwrseq_engine
    import pwrseq_pkg::*;
#(
    parameter int N_ENTRIES  = 2,
    parameter logic [N_ENTRIES*ENTRY_W-1:0] TABLE = {N_ENTRIES{STOP_STEP}},
    parameter int POLL_LIMIT = 10000,
    parameter int CYC_PER_US = 125,
    parameter int US_PER_MS  = 1000
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    input  logic [7:0]                       cfg_cut,
    input  logic [3:0]                       cfg_fab,
    input  logic [3:0]                       cfg_port,
    output logic                             bus_rd,
    output logic                             bus_wr,
    output logic [19:0]                      bus_addr,
    output logic [7:0]                       bus_wdata,
    input  logic [7:0]                       bus_rdata,
    input  logic                             bus_ready,
    output logic                             busy,
    output logic                             done,
    output logic                             error,
    output logic [$clog2(N_ENTRIES+1)-1:0]   fail_idx,
    output logic [7:0]                       rd_value
);
    localparam int IDX_W = $clog2(N_ENTRIES + 1);
    localparam int CNT_W = $clog2(POLL_LIMIT + 1);

    typedef struct packed {
        state_e           st;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] tries;
        logic [7:0]       wbuf;
        logic [7:0]       rval;
        logic             err;
        logic [IDX_W-1:0] fidx;
    } core_t;

    core_t c_d, c_q;
    step_t cur;
    logic  past_end, hit, tmr_load, tmr_expired, poll_ok;
    int    sel;

    always_comb begin
        past_end = (c_q.idx >= IDX_W'(N_ENTRIES));
        sel      = past_end ? 0 : int'(c_q.idx);
        cur      = past_end ? STOP_STEP : step_t'(TABLE[sel*ENTRY_W +: ENTRY_W]);
        poll_ok  = (((bus_rdata ^ cur.data) & cur.bitmask) == 8'h00);
    end

    pwrseq_match u_match (
        .cut_sel (cur.cut_sel),
        .fab_sel (cur.fab_sel),
        .port_sel(cur.port_sel),
        .cfg_cut (cfg_cut),
        .cfg_fab (cfg_fab),
        .cfg_port(cfg_port),
        .hit     (hit)
    );

    pwrseq_timer #(
        .CYC_PER_US(CYC_PER_US),
        .US_PER_MS (US_PER_MS)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .amount (cur.offset),
        .unit_ms(cur.data[0]),
        .expired(tmr_expired)
    );

    always_comb begin
        c_d      = c_q;
        tmr_load = 1'b0;
        unique case (c_q.st)
            ST_IDLE, ST_DONE: begin
                if (start) begin
                    c_d.st    = ST_EVAL;
                    c_d.idx   = '0;
                    c_d.tries = '0;
                    c_d.err   = 1'b0;
                    c_d.fidx  = '0;
                end
            end
            ST_EVAL: begin
                if (past_end) begin
                    c_d.err  = 1'b1;
                    c_d.fidx = c_q.idx;
                    c_d.st   = ST_DONE;
                end else if (!hit) begin
                    c_d.idx = c_q.idx + 1'b1;
                end else begin
                    case (cur.op)
                        OP_READ, OP_WRITE, OP_POLL: begin
                            c_d.st    = ST_READ;
                            c_d.tries = '0;
                        end
                        OP_DELAY: begin
                            tmr_load = 1'b1;
                            c_d.st   = ST_WAIT;
                        end
                        OP_END:  c_d.st = ST_DONE;
                        default: begin
                            c_d.err  = 1'b1;
                            c_d.fidx = c_q.idx;
                            c_d.st   = ST_DONE;
                        end
                    endcase
                end
            end
            ST_READ: begin
                if (bus_ready) begin
                    if (cur.op == OP_READ) begin
                        c_d.rval = bus_rdata & cur.bitmask;
                        c_d.idx  = c_q.idx + 1'b1;
                        c_d.st   = ST_EVAL;
                    end else if (cur.op == OP_WRITE) begin
                        c_d.wbuf = (bus_rdata & ~cur.bitmask) | (cur.data & cur.bitmask);
                        c_d.st   = ST_WRITE;
                    end else if (poll_ok) begin
                        c_d.idx = c_q.idx + 1'b1;
                        c_d.st  = ST_EVAL;
                    end else if (c_q.tries == CNT_W'(POLL_LIMIT - 1)) begin
                        c_d.err  = 1'b1;
                        c_d.fidx = c_q.idx;
                        c_d.st   = ST_DONE;
                    end else begin
                        c_d.tries = c_q.tries + 1'b1;
                    end
                end
            end
            ST_WRITE: begin
                if (bus_ready) begin
                    c_d.idx = c_q.idx + 1'b1;
                    c_d.st  = ST_EVAL;
                end
            end
            ST_WAIT: begin
                if (tmr_expired) begin
                    c_d.idx = c_q.idx + 1'b1;
                    c_d.st  = ST_EVAL;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q    <= '0;
            c_q.st <= ST_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign bus_rd    = (c_q.st == ST_READ);
    assign bus_wr    = (c_q.st == ST_WRITE);
    assign bus_addr  = {cur.space, cur.offset};
    assign bus_wdata = c_q.wbuf;
    assign busy      = (c_q.st != ST_IDLE) && (c_q.st != ST_DONE);
    assign done      = (c_q.st == ST_DONE);
    assign error     = c_q.err && done;
    assign fail_idx  = c_q.fidx;
    assign rd_value  = c_q.rval;

    AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr)) else $error("read and write together"); // R10
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) && !bus_ready |=> $stable(bus_addr) && $stable(bus_wdata))
        else $error("address moved before ready"); // R10
    AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == ST_EVAL) && !past_end && !hit |=> !bus_rd && !bus_wr)
        else $error("skipped step touched the bus"); // R2
    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_wr) |-> $past(bus_rd && bus_ready))
        else $error("write without preceding read"); // R4
    AST_TRIES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> (c_q.tries < CNT_W'(POLL_LIMIT)))
        else $error("poll attempts over budget"); // R6
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done && (error == $past(error)))
        else $error("done or error changed without start"); // R8
    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start |=> busy || done)
        else $error("start disturbed a running sequence"); // R11

endmodule

// File: tb/test_pwrseq_engine.sv
`timescale 1ns/1ps
module test_pwrseq_engine;
    localparam int N     = 10;
    localparam int LIMIT = 6;
    localparam int CPU   = 2;
    localparam int UPM   = 4;

    localparam logic [19:0] A_ADDR = {4'h1, 16'h0002};
    localparam logic [19:0] B_ADDR = {4'h0, 16'h0001};
    localparam logic [19:0] C_ADDR = {4'h2, 16'h0003};
    localparam logic [19:0] P_ADDR = {4'h3, 16'h0010};

    function automatic logic [55:0] mk(input logic [15:0] off, input logic [7:0] cut,
                                       input logic [3:0] fab, input logic [3:0] prt,
                                       input logic [3:0] spc, input logic [3:0] op,
                                       input logic [7:0] msk, input logic [7:0] val);
        return {off, cut, fab, prt, spc, op, msk, val};
    endfunction

    localparam logic [N*56-1:0] TBL = {
        mk(16'h0000, 8'hFF, 4'h4, 4'hF, 4'h0, 4'd4, 8'h00, 8'h00), // 9 end, site bit2
        mk(16'h0000, 8'hFF, 4'h2, 4'hF, 4'h0, 4'd7, 8'h00, 8'h00), // 8 bad code, site bit1
        mk(16'h0000, 8'hFF, 4'h1, 4'hF, 4'h0, 4'd4, 8'h00, 8'h00), // 7 end, site bit0
        mk(16'h0010, 8'hFF, 4'hF, 4'hF, 4'h3, 4'd2, 8'hFF, 8'hA5), // 6 poll
        mk(16'h0003, 8'hFF, 4'hF, 4'h2, 4'h2, 4'd1, 8'hF0, 8'h90), // 5 write, link bit1
        mk(16'h0003, 8'hFF, 4'hF, 4'h1, 4'h2, 4'd1, 8'hFF, 8'h5A), // 4 write, link bit0
        mk(16'h0002, 8'h02, 4'hF, 4'hF, 4'h0, 4'd3, 8'h00, 8'h01), // 3 wait 2 ms, revision bit1
        mk(16'h0003, 8'hFF, 4'hF, 4'hF, 4'h0, 4'd3, 8'h00, 8'h00), // 2 wait 3 us
        mk(16'h0001, 8'hFF, 4'hF, 4'hF, 4'h0, 4'd0, 8'h0F, 8'h00), // 1 read
        mk(16'h0002, 8'hFF, 4'hF, 4'hF, 4'h1, 4'd1, 8'h3C, 8'h14)  // 0 write
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [7:0] cfg_cut = 8'h01;
    logic [3:0] cfg_fab = 4'h1, cfg_port = 4'h1;
    logic bus_rd, bus_wr, bus_ready = 1'b0;
    logic [19:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata, rd_value;
    logic busy, done, error;
    logic [3:0] fail_idx;

    always #4 clk = ~clk;

    pwrseq_engine #(.N_ENTRIES(N), .TABLE(TBL), .POLL_LIMIT(LIMIT),
                    .CYC_PER_US(CPU), .US_PER_MS(UPM)) i_pwrseq_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_cut(cfg_cut), .cfg_fab(cfg_fab),
        .cfg_port(cfg_port), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .busy(busy), .done(done), .error(error), .fail_idx(fail_idx), .rd_value(rd_value));

    logic [7:0] mem [256];
    int poll_cnt, target, cnt_a, cnt_c, overlap, cyc, t_rd, t_poll;
    logic poll_seen, pend, pend_wr;
    logic [19:0] pend_addr;
    logic [7:0] pend_data;
    int total = 0, bad = 0;

    function automatic int mi(input logic [19:0] a);
        return int'({a[17:16], a[5:0]});
    endfunction

    assign bus_rdata = (bus_addr == P_ADDR) ? ((poll_cnt >= target) ? 8'hA5 : 8'h00)
                                            : mem[mi(bus_addr)];

    initial begin
        pend = 1'b0; poll_cnt = 0; target = 0; cnt_a = 0; cnt_c = 0; overlap = 0;
        cyc = 0; t_rd = 0; t_poll = 0; poll_seen = 1'b0;
        pend_wr = 1'b0; pend_addr = '0; pend_data = '0;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    end

    // Register model: effects of an access are applied half a cycle after it completes.
    always @(negedge clk) begin
        cyc++;
        if (pend) begin
            if (pend_wr) mem[mi(pend_addr)] = pend_data;
            if (pend_addr == P_ADDR) poll_cnt++;
            if (pend_addr == A_ADDR) cnt_a++;
            if (pend_addr == C_ADDR) cnt_c++;
        end
        if (bus_rd && bus_wr) overlap++;
        bus_ready = (($urandom % 4) != 0);
        pend      = (bus_rd || bus_wr) && bus_ready;
        pend_wr   = bus_wr;
        pend_addr = bus_addr;
        pend_data = bus_wdata;
        if (pend && bus_rd && bus_addr == B_ADDR) t_rd = cyc;
        if (bus_rd && bus_addr == P_ADDR && !poll_seen) begin
            poll_seen = 1'b1;
            t_poll = cyc;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rmw(input logic [7:0] old, input logic [7:0] m, input logic [7:0] v);
        return (old & ~m) | (v & m);
    endfunction

    task automatic run(input logic [7:0] cut, input logic [3:0] fab, input logic [3:0] prt,
                       input int tgt);
        logic [7:0] ia, ib, ic, exp_c;
        bit exp_err, timed_out;
        int exp_idx, waited, gap;
        @(posedge clk); #1;
        ia = 8'($urandom); ib = 8'($urandom); ic = 8'($urandom);
        mem[mi(A_ADDR)] = ia; mem[mi(B_ADDR)] = ib; mem[mi(C_ADDR)] = ic;
        cfg_cut = cut; cfg_fab = fab; cfg_port = prt; target = tgt;
        poll_cnt = 0; cnt_a = 0; cnt_c = 0; overlap = 0; poll_seen = 1'b0; t_rd = 0; t_poll = 0;
        start = 1'b1;
        @(posedge clk); #1; start = 1'b0;
        repeat (3) @(posedge clk);
        #1; start = 1'b1;                      // R11: pulse while busy
        @(posedge clk); #1; start = 1'b0;
        waited = 0; timed_out = 1'b0;
        while (!done) begin
            @(negedge clk);
            waited++;
            if (waited > 3000) begin timed_out = 1'b1; break; end
        end
        chk(!timed_out, "watchdog", waited, 3000);
        repeat (2) @(negedge clk);
        if (tgt >= LIMIT)       begin exp_err = 1'b1; exp_idx = 6; end
        else if (fab == 4'h2)   begin exp_err = 1'b1; exp_idx = 8; end
        else if (fab == 4'h8)   begin exp_err = 1'b1; exp_idx = N; end
        else                    begin exp_err = 1'b0; exp_idx = 0; end
        chk(done && !busy, "R8 done", {busy, done}, 2'b01);
        chk(error == exp_err, "R6/R8/R9/R12 error", error, exp_err);
        if (exp_err) chk(int'(fail_idx) == exp_idx, "R6/R9/R12 fail_idx", fail_idx, exp_idx);
        chk(mem[mi(A_ADDR)] == rmw(ia, 8'h3C, 8'h14), "R4 rmw", mem[mi(A_ADDR)], rmw(ia, 8'h3C, 8'h14));
        chk(cnt_a == 2, "R11 single run", cnt_a, 2);
        chk(rd_value == (ib & 8'h0F), "R3 read", rd_value, ib & 8'h0F);
        if (prt == 4'h1)      exp_c = 8'h5A;
        else if (prt == 4'h2) exp_c = rmw(ic, 8'hF0, 8'h90);
        else                  exp_c = ic;
        chk(mem[mi(C_ADDR)] == exp_c, "R2 link filter", mem[mi(C_ADDR)], exp_c);
        chk(cnt_c == ((prt[0] | prt[1]) ? 2 : 0), "R2 no access", cnt_c, (prt[0] | prt[1]) ? 2 : 0);
        if (tgt >= LIMIT) chk(poll_cnt == LIMIT, "R6 attempts", poll_cnt, LIMIT);
        else              chk(poll_cnt == tgt + 1, "R5 attempts", poll_cnt, tgt + 1);
        chk(overlap == 0, "R10 exclusive", overlap, 0);
        if (prt[2] | prt[3]) begin
            gap = 13 + ((cut == 8'h02) ? 17 : 0);
            chk((t_poll - t_rd) >= gap - 1 && (t_poll - t_rd) <= gap + 1, "R7 wait length",
                t_poll - t_rd, gap);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !error && !bus_rd && !bus_wr, "R1 reset",
            {busy, done, error, bus_rd, bus_wr}, 0);
        rst_n = 1'b1;
        void'($urandom(32'd20240611));
        run(8'h02, 4'h1, 4'h4, 0);           // ms wait, clean end
        run(8'h01, 4'h1, 4'h8, 2);           // us wait only
        run(8'h04, 4'h4, 4'h1, LIMIT - 1);   // match on the last attempt
        run(8'h80, 4'h1, 4'h2, LIMIT);       // timeout
        run(8'h02, 4'h2, 4'h4, 1);           // bad command code
        run(8'h10, 4'h8, 4'h1, 0);           // table exhausted
        for (int k = 0; k < 20; k++) begin
            run(8'(1 << ($urandom % 8)), 4'(1 << ($urandom % 4)), 4'(1 << ($urandom % 4)),
                int'($urandom % (LIMIT + 2)));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule